// File: doc/BRIEF.md
# Segmented Receive Stream Framing Monitor

This block is a passive observer for a receive bus that is split into a fixed number of segments. Each beat carries, per segment, an enable and start and end markers. One valid signal qualifies the whole beat, and nothing can push back on the sender. Any beat with valid high is consumed in the cycle it appears. The monitor follows the open or closed state of a frame from beat to beat and through stalls. For every valid beat it reports which framing rules were broken.

Five violation flags come out one clock after the offending beat. A sticky summary collects them until reset. A running count of properly closed frames is kept. Two lane pulses show which preamble lane each accepted start maps to: a start in segments 0 to 3 belongs to lane 0, and a start in segments 4 to 7 belongs to lane 1. The segment count is a parameter and may be 4 or 8. Payload contents and checksums are not examined.

Top module: `segrx_monitor`

## Requirements
- R1: On a valid beat, a start marker on an enabled segment k>0 sets `viol_align` unless segment k-1 of the same beat is enabled and carries an end marker. Segment i of every per-segment bus is bit i.
- R2: On a valid beat, a start marker on an enabled segment while a frame is still open sets `viol_noend`.
- R3: On a valid beat, an end marker on an enabled segment while no frame is open sets `viol_orphan`. A start and an end on the same segment form a legal one-segment frame.
- R4: On a valid beat, a disabled segment met while a frame is open sets `viol_gap`.
- R5: On a valid beat, `viol_stray` is set by either of two cases: an enabled segment with no markers outside any frame, or a start or end marker on a disabled segment.
- R6: While `in_valid` is low, the inputs are ignored. No flag rises, no lane pulse appears, the frame count holds, and an open frame stays open for any number of cycles.
- R7: Each flag is registered and appears in the cycle after its beat. `sticky_err` is the OR of all flags seen since reset and clears only on reset.
- R8: `frame_count` rises by the number of end markers that close an open frame in a beat. This can be more than one per beat.
- R9: `pre_lane[0]` pulses one cycle after a valid beat that has an enabled start in segments 0 to 3. `pre_lane[1]` pulses for a start in segments 4 to 7, and it never pulses when NSEG is 4.
- R10: After reset, all flags, `sticky_err`, `pre_lane` and `frame_count` are zero, and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat qualifier for the whole bus |
| seg_ena | input | NSEG | Per-segment enable |
| seg_sop | input | NSEG | Per-segment start marker |
| seg_eop | input | NSEG | Per-segment end marker |
| viol_align | output | 1 | Start not aligned to a preceding end or to segment 0 |
| viol_noend | output | 1 | Start while a frame is open |
| viol_orphan | output | 1 | End with no open frame |
| viol_gap | output | 1 | Disabled segment inside a frame |
| viol_stray | output | 1 | Data or marker outside any frame |
| sticky_err | output | 1 | OR of all flags since reset |
| frame_count | output | CNT_W | Closed-frame counter |
| pre_lane | output | 2 | Preamble lane pulses for accepted starts |

## Verification
The bench builds two instances. The main one uses NSEG=8, which makes it possible to have several frames start and close in one beat, to tag starts to the upper preamble lane, and to place a misaligned start deep inside a beat. A second instance with NSEG=4 checks that the lane tagging collapses to lane 0 and that the closed-frame count still steps by more than one per beat. Randomized legal traffic with stalls is expected to produce no flags. Each kind of violation is then injected on its own, and only its own flag is expected to rise.

// File: rtl/segrx_pkg.sv
package segrx_pkg;

  typedef struct packed {
    logic open_out;
    logic close;
    logic v_align;
    logic v_noend;
    logic v_orphan;
    logic v_gap;
    logic v_stray;
  } seg_res_t;

  // Rules for one segment, given whether a frame is open on entry and
  // whether the neighbour below ended a frame (always true for segment 0).
  function automatic seg_res_t seg_eval(input logic open_in, input logic ena,
                                        input logic sop, input logic eop,
                                        input logic prev_ok);
    seg_res_t r;
    logic     open_mid;
    r = '0;
    if (ena) begin
      open_mid   = sop | open_in;
      r.v_align  = sop & ~prev_ok;
      r.v_noend  = sop & open_in;
      r.v_orphan = eop & ~open_mid;
      r.close    = eop & open_mid;
      r.v_stray  = ~sop & ~eop & ~open_in;
      r.open_out = open_mid & ~eop;
    end else begin
      r.v_gap    = open_in;
      r.v_stray  = sop | eop;
      r.open_out = open_in;
    end
    return r;
  endfunction

endpackage

// File: rtl/segrx_cell.sv
module segrx_cell
  import segrx_pkg::*;
(
  input  logic     open_in,
  input  logic     ena,
  input  logic     sop,
  input  logic     eop,
  input  logic     prev_ok,
  output seg_res_t res
);
  always_comb res = seg_eval(open_in, ena, sop, eop, prev_ok);
endmodule

// File: rtl/segrx_lane.sv
module segrx_lane #(
  parameter int NSEG = 8
) (
  input  logic [NSEG-1:0] starts,
  output logic [1:0]      lane
);
  localparam int LO_N = (NSEG > 4) ? 4 : NSEG;

  assign lane[0] = |starts[LO_N-1:0];
  generate
    if (NSEG > LO_N) begin : g_hi
      assign lane[1] = |starts[NSEG-1:LO_N];
    end else begin : g_nohi
      assign lane[1] = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/segrx_monitor.sv
module segrx_monitor
  import segrx_pkg::*;
#(
  parameter int NSEG  = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NSEG-1:0]  seg_ena,
  input  logic [NSEG-1:0]  seg_sop,
  input  logic [NSEG-1:0]  seg_eop,
  output logic             viol_align,
  output logic             viol_noend,
  output logic             viol_orphan,
  output logic             viol_gap,
  output logic             viol_stray,
  output logic             sticky_err,
  output logic [CNT_W-1:0] frame_count,
  output logic [1:0]       pre_lane
);
  localparam int ADD_W = $clog2(NSEG + 1);

  logic            frame_open;
  logic [NSEG:0]   open_c;
  seg_res_t        res [NSEG];
  logic [NSEG-1:0] align_v, noend_v, orphan_v, gap_v, stray_v;
  logic [ADD_W-1:0] close_sum;
  logic [1:0]      lane_c;

  // Named beat events for the checker
  logic ev_align, ev_noend, ev_orphan, ev_gap, ev_stray, ev_any;

  assign open_c[0] = frame_open;

  generate
    for (genvar i = 0; i < NSEG; i++) begin : g_seg
      logic prev_ok;
      if (i == 0) begin : g_first
        assign prev_ok = 1'b1;
      end else begin : g_rest
        assign prev_ok = seg_ena[i-1] & seg_eop[i-1];
      end
      segrx_cell u_cell (
        .open_in (open_c[i]),
        .ena     (seg_ena[i]),
        .sop     (seg_sop[i]),
        .eop     (seg_eop[i]),
        .prev_ok (prev_ok),
        .res     (res[i])
      );
      assign open_c[i+1] = res[i].open_out;
      assign align_v[i]  = res[i].v_align;
      assign noend_v[i]  = res[i].v_noend;
      assign orphan_v[i] = res[i].v_orphan;
      assign gap_v[i]    = res[i].v_gap;
      assign stray_v[i]  = res[i].v_stray;
    end
  endgenerate

  always_comb begin
    close_sum = '0;
    for (int i = 0; i < NSEG; i++) close_sum = close_sum + ADD_W'(res[i].close);
  end

  segrx_lane #(.NSEG(NSEG)) u_lane (
    .starts (seg_ena & seg_sop),
    .lane   (lane_c)
  );

  assign ev_align  = in_valid & |align_v;
  assign ev_noend  = in_valid & |noend_v;
  assign ev_orphan = in_valid & |orphan_v;
  assign ev_gap    = in_valid & |gap_v;
  assign ev_stray  = in_valid & |stray_v;
  assign ev_any    = ev_align | ev_noend | ev_orphan | ev_gap | ev_stray;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_open  <= 1'b0;
      viol_align  <= 1'b0;
      viol_noend  <= 1'b0;
      viol_orphan <= 1'b0;
      viol_gap    <= 1'b0;
      viol_stray  <= 1'b0;
      sticky_err  <= 1'b0;
      frame_count <= '0;
      pre_lane    <= 2'b00;
    end else begin
      viol_align  <= ev_align;
      viol_noend  <= ev_noend;
      viol_orphan <= ev_orphan;
      viol_gap    <= ev_gap;
      viol_stray  <= ev_stray;
      sticky_err  <= sticky_err | ev_any;
      pre_lane    <= in_valid ? lane_c : 2'b00;
      if (in_valid) begin
        frame_open  <= open_c[NSEG];
        frame_count <= frame_count + CNT_W'(close_sum);
      end
    end
  end
endmodule

// File: rtl/segrx_monitor_chk.sv
module segrx_monitor_chk #(
  parameter int NSEG  = 8,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [NSEG-1:0]  seg_ena,
  input logic [NSEG-1:0]  seg_sop,
  input logic [NSEG-1:0]  seg_eop,
  input logic             frame_open,
  input logic             viol_align,
  input logic             viol_noend,
  input logic             viol_orphan,
  input logic             viol_gap,
  input logic             viol_stray,
  input logic             sticky_err,
  input logic [CNT_W-1:0] frame_count,
  input logic [1:0]       pre_lane
);
  logic any_flag;
  assign any_flag = viol_align | viol_noend | viol_orphan | viol_gap | viol_stray;

  AST_ALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && seg_ena[1] && seg_sop[1] && !(seg_ena[0] && seg_eop[0]) |=> viol_align); // R1
  AST_NOEND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && frame_open && seg_ena[0] && seg_sop[0] |=> viol_noend); // R2
  AST_ORPHAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !frame_open && seg_ena[0] && seg_eop[0] && !seg_sop[0] |=> viol_orphan); // R3
  AST_GAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && frame_open && !seg_ena[0] |=> viol_gap); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !any_flag && pre_lane == 2'b00 && $stable(frame_count)); // R6
  AST_OPEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(frame_open)); // R6
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_err |=> sticky_err); // R7
  AST_STICKY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    any_flag |-> sticky_err); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_count - $past(frame_count)) <= CNT_W'(NSEG)); // R8
endmodule

bind segrx_monitor segrx_monitor_chk #(.NSEG(NSEG), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_ena(seg_ena),
  .seg_sop(seg_sop), .seg_eop(seg_eop), .frame_open(frame_open),
  .viol_align(viol_align), .viol_noend(viol_noend), .viol_orphan(viol_orphan),
  .viol_gap(viol_gap), .viol_stray(viol_stray), .sticky_err(sticky_err),
  .frame_count(frame_count), .pre_lane(pre_lane)
);

// File: tb/tb_segrx_monitor.sv
module tb_segrx_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // 8-segment instance
  logic        in_valid = 1'b0;
  logic [7:0]  ena = '0, sop = '0, eop = '0;
  logic        f_al, f_ne, f_or, f_gp, f_st, sticky;
  logic [31:0] fcount;
  logic [1:0]  lane;

  segrx_monitor #(.NSEG(8), .CNT_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_ena(ena),
    .seg_sop(sop), .seg_eop(eop), .viol_align(f_al), .viol_noend(f_ne),
    .viol_orphan(f_or), .viol_gap(f_gp), .viol_stray(f_st),
    .sticky_err(sticky), .frame_count(fcount), .pre_lane(lane)
  );

  // 4-segment instance
  logic        w_valid = 1'b0;
  logic [3:0]  w_ena = '0, w_sop = '0, w_eop = '0;
  logic        w_al, w_ne, w_or, w_gp, w_st, w_sticky;
  logic [31:0] w_count;
  logic [1:0]  w_lane;

  segrx_monitor #(.NSEG(4), .CNT_W(32)) dut4 (
    .clk(clk), .rst_n(rst_n), .in_valid(w_valid), .seg_ena(w_ena),
    .seg_sop(w_sop), .seg_eop(w_eop), .viol_align(w_al), .viol_noend(w_ne),
    .viol_orphan(w_or), .viol_gap(w_gp), .viol_stray(w_st),
    .sticky_err(w_sticky), .frame_count(w_count), .pre_lane(w_lane)
  );

  function automatic logic [4:0] flags8();
    return {f_al, f_ne, f_or, f_gp, f_st};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Drive one beat at a falling edge, return at the next falling edge
  // when the registered results of that beat are visible.
  task automatic beat(input logic v, input logic [7:0] e, input logic [7:0] s, input logic [7:0] p);
    in_valid = v; ena = e; sop = s; eop = p;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0; ena = '0; sop = '0; eop = '0;
    w_valid = 1'b0; w_ena = '0; w_sop = '0; w_eop = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R10 flags", 32'(flags8()), 32'd0);
    check("R10 sticky", 32'(sticky), 32'd0);
    check("R10 count", fcount, 32'd0);
    check("R10 lane", 32'(lane), 32'd0);
  endtask

  task automatic t_random_legal();
    logic open = 1'b0;
    int   expc = 0;
    do_reset();
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 4 == 0) begin
        beat(1'b0, 8'($urandom), 8'($urandom), 8'($urandom));
        check("R6 stall flags", 32'(flags8()), 32'd0);
        check("R6 stall lane", 32'(lane), 32'd0);
      end else begin
        logic [7:0] e = '0, s = '0, p = '0;
        logic       start = ~open;
        logic       done = 1'b0;
        logic [1:0] le = 2'b00;
        for (int i = 0; i < 8; i++) begin
          if (!done) begin
            e[i] = 1'b1;
            if (start) begin
              s[i] = 1'b1; start = 1'b0; open = 1'b1;
              if (i < 4) le[0] = 1'b1; else le[1] = 1'b1;
            end
            if ($urandom % 5 == 0) begin
              p[i] = 1'b1; open = 1'b0; expc++;
              if (i < 7 && ($urandom % 2 == 1)) start = 1'b1;
              else done = 1'b1;
            end
          end
        end
        beat(1'b1, e, s, p);
        check("R1-legal flags zero", 32'(flags8()), 32'd0);
        check("R9 lane", 32'(lane), 32'(le));
      end
    end
    check("R8 random count", fcount, 32'(expc));
    check("R7 sticky clean", 32'(sticky), 32'd0);
  endtask

  task automatic t_align();
    do_reset();
    beat(1'b1, 8'hFC, 8'h04, 8'h00);
    check("R1 misaligned start", 32'(flags8()), 32'b10000);
    check("R7 sticky set", 32'(sticky), 32'd1);
    beat(1'b1, 8'hFF, 8'h00, 8'h80);
    // End closes frame; a start at seg 2 after a clean boundary is misaligned
    beat(1'b1, 8'h3C, 8'h04, 8'h20);
    check("R1 start off segment 0 after boundary", 32'(flags8()), 32'b10000);
  endtask

  task automatic t_noend();
    do_reset();
    beat(1'b1, 8'hFF, 8'h01, 8'h00);
    check("R2 first start ok", 32'(flags8()), 32'd0);
    beat(1'b1, 8'hFF, 8'h01, 8'h00);
    check("R2 start while open", 32'(flags8()), 32'b01000);
  endtask

  task automatic t_orphan();
    do_reset();
    beat(1'b1, 8'h01, 8'h00, 8'h01);
    check("R3 orphan end", 32'(flags8()), 32'b00100);
    check("R8 orphan not counted", fcount, 32'd0);
  endtask

  task automatic t_gap();
    do_reset();
    beat(1'b1, 8'hFF, 8'h01, 8'h00);
    beat(1'b0, 8'h00, 8'h00, 8'h00);
    beat(1'b1, 8'hEF, 8'h00, 8'h80);
    check("R4 hole inside frame", 32'(flags8()), 32'b00010);
    check("R8 gap frame still closes", fcount, 32'd1);
  endtask

  task automatic t_stray();
    do_reset();
    beat(1'b1, 8'h1F, 8'h01, 8'h08);
    check("R5 enabled segment after end", 32'(flags8()), 32'b00001);
    beat(1'b1, 8'h7F, 8'h01, 8'hC0);
    check("R5 marker on disabled segment", 32'(flags8()), 32'b00001);
  endtask

  task automatic t_stall_hold();
    do_reset();
    beat(1'b1, 8'hFF, 8'h01, 8'h00);
    for (int k = 0; k < 6; k++) begin
      beat(1'b0, 8'hFF, 8'h11, 8'h22);
      check("R6 ignored while idle", 32'({flags8(), lane}), 32'd0);
    end
    check("R6 count held", fcount, 32'd0);
    // Frame must still be open: a mid-frame beat with no start is clean
    beat(1'b1, 8'hFF, 8'h00, 8'h80);
    check("R6 open held through stall", 32'(flags8()), 32'd0);
    check("R8 closed after stall", fcount, 32'd1);
  endtask

  task automatic t_multi();
    do_reset();
    beat(1'b1, 8'hFF, 8'h49, 8'hA4);
    check("R8 three closes in one beat", fcount, 32'd3);
    check("R9 both lanes", 32'(lane), 32'd3);
    check("R1 back-to-back starts legal", 32'(flags8()), 32'd0);
    beat(1'b1, 8'hF0, 8'h10, 8'h00);
    check("R1 upper start after clean end", 32'(flags8()), 32'b10000);
    check("R9 upper lane only", 32'(lane), 32'd2);
  endtask

  task automatic t_sticky();
    do_reset();
    beat(1'b1, 8'h01, 8'h00, 8'h01);
    for (int k = 0; k < 3; k++) beat(1'b1, 8'h01, 8'h01, 8'h01);
    check("R7 flag cleared next clean beat", 32'(flags8()), 32'd0);
    check("R7 sticky persists", 32'(sticky), 32'd1);
    do_reset();
    check("R7 sticky reset", 32'(sticky), 32'd0);
  endtask

  task automatic t_four_seg();
    do_reset();
    w_valid = 1'b1; w_ena = 4'hF; w_sop = 4'h5; w_eop = 4'hA;
    @(negedge clk);
    w_valid = 1'b0;
    check("R8 four-seg two closes", w_count, 32'd2);
    check("R9 four-seg lane 0 only", 32'(w_lane), 32'd1);
    check("R1 four-seg flags", 32'({w_al, w_ne, w_or, w_gp, w_st}), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_random_legal();
    t_align();
    t_noend();
    t_orphan();
    t_gap();
    t_stray();
    t_stall_hold();
    t_multi();
    t_sticky();
    t_four_seg();
    summary();
    $finish;
  end
endmodule